// File: doc/BRIEF.md
# Store Queue with Read Bypass

This block holds the stores that a write-through data cache has already applied to its own arrays but that slow main memory has not yet absorbed. The processor side offers an address/data pair together with every store it writes into the cache. The queue keeps up to four of them in arrival order. It hands them one at a time, oldest first, to a single memory request port. When the queue is full, the processor sees back-pressure and must stall.

A read miss does not wait for the queue to empty. Its address is compared in parallel with every pending store. If nothing matches, the read takes the memory port in that cycle, ahead of any queued write. If one or more stores match, the read is answered locally with the data of the youngest matching store. The memory port then stays free for draining.

Top module: `stq_bypass`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `push_ready`=1 and `mem_req`=0 while no read is offered.
- R2: A push with `push_valid`=1 and `push_ready`=1 is stored at a rising edge. `full` rises once four stores are pending, and `empty` falls after the first store.
- R3: While `full`=1, `push_ready` is 0 and a push is refused even if a drain happens in the same cycle. The refused pair never appears on the memory port.
- R4: Without a read, a non-empty queue drives `mem_req`=1, `mem_we`=1 and the oldest entry's address and data. An entry leaves the queue only at an edge where `mem_gnt`=1.
- R5: A read whose address matches no pending entry drives `mem_req`=1, `mem_we`=0 and `mem_addr`=`rd_addr`. `rd_ready` equals `mem_gnt`, and `rd_hit`=0.
- R6: A read whose address matches a pending entry gives `rd_hit`=1 and `rd_ready`=1 in the same cycle, with `rd_data` equal to the data of the most recently pushed matching entry. No memory read is issued.
- R7: When a conflict-free read and a pending write both want the memory port, the read wins. No entry is drained in that cycle.
- R8: With the queue empty and no read offered, `mem_req` is 0. A store pushed in the current cycle is not visible to the address check until the next cycle.
- R9: A push and a drain at the same edge while not full leave the count unchanged and keep the first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Processor offers a store |
| push_addr | input | AW | Store address |
| push_data | input | DW | Store data |
| push_ready | output | 1 | Store accepted this cycle (not full) |
| rd_valid | input | 1 | Read miss offered |
| rd_addr | input | AW | Read miss address |
| rd_ready | output | 1 | Read completed: forwarded or taken by memory |
| rd_hit | output | 1 | Read answered from a pending store |
| rd_data | output | DW | Forwarded data, valid with `rd_hit` |
| mem_req | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = write of oldest store, 0 = read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| full | output | 1 | Four stores pending |
| empty | output | 1 | No store pending |

## Verification
Two things can fall in the same cycle and compete: the memory port can carry either the oldest pending write or a conflict-free read, and a forwarded read can run alongside a drain of the head entry. The bench provokes both collisions by holding the queue partly full while it offers reads with `mem_gnt` high. It compares the port direction and the queue occupancy that follows against a reference queue kept in the bench. A long stretch of mixed random pushes, reads over every address and grant patterns then checks forwarding, youngest-match selection and ordering at each cycle.

// File: rtl/stq_pkg.sv
package stq_pkg;

  // slot that lies 'age' positions after 'head' on a ring of 'depth' slots
  function automatic int unsigned ring_slot(int unsigned head, int unsigned age,
                                            int unsigned depth);
    return (head + age) % depth;
  endfunction

endpackage

// File: rtl/stq_entries.sv
module stq_entries #(
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [AW-1:0] ent_addr [DEPTH],
  output logic [DW-1:0] ent_data [DEPTH],
  output logic [DEPTH-1:0] ent_vld,
  output logic [PW-1:0] head_ptr,
  output logic          full,
  output logic          empty
);
  import stq_pkg::*;

  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      head_ptr <= '0;
      count    <= '0;
      ent_vld  <= '0;
    end else begin
      if (push_en) begin
        wr_ptr          <= PW'(ring_slot(wr_ptr, 1, DEPTH));
        ent_vld[wr_ptr] <= 1'b1;
      end
      if (pop_en) begin
        head_ptr <= PW'(ring_slot(head_ptr, 1, DEPTH));
        if (!(push_en && wr_ptr == head_ptr)) ent_vld[head_ptr] <= 1'b0;
      end
      if (push_en && !pop_en)      count <= count + 1'b1;
      else if (pop_en && !push_en) count <= count - 1'b1;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_en && wr_ptr == PW'(s)) begin
        ent_addr[s] <= push_addr;
        ent_data[s] <= push_data;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_en); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !empty); // R4
  AST_COUNT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |=> (count == $past(count))); // R9
  AST_VLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_vld) == int'(count)); // R2

endmodule

// File: rtl/stq_match.sv
module stq_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [DW-1:0]    ent_data [DEPTH],
  input  logic [DEPTH-1:0] ent_vld,
  input  logic [PW-1:0]    head_ptr,
  output logic             hit,
  output logic [DW-1:0]    fwd_data
);
  import stq_pkg::*;

  logic [DEPTH-1:0] slot_match;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign slot_match[s] = ent_vld[s] && (ent_addr[s] == rd_addr);
  end

  assign hit = |slot_match;

  // walk from oldest to youngest; the last match seen wins
  always_comb begin
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (slot_match[ring_slot(head_ptr, k, DEPTH)])
        fwd_data = ent_data[ring_slot(head_ptr, k, DEPTH)];
    end
  end

endmodule

// File: rtl/stq_arb.sv
module stq_arb #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rd_ready,
  output logic          rd_issue,
  output logic          drain_fire
);
  assign rd_issue   = rd_valid && !hit;
  assign mem_req    = rd_issue || !empty;
  assign mem_we     = !rd_issue;
  assign mem_addr   = rd_issue ? rd_addr : head_addr;
  assign mem_wdata  = head_data;
  assign drain_fire = !rd_issue && !empty && mem_gnt;
  assign rd_ready   = rd_valid && (hit || mem_gnt);

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !hit) |-> (mem_req && !mem_we && mem_addr == rd_addr)); // R5
  AST_FWD_NO_MEMREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && hit) |-> (rd_ready && (!mem_req || mem_we))); // R6
  AST_READ_BLOCKS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !drain_fire); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_valid) |-> !mem_req); // R8

endmodule

// File: rtl/stq_bypass.sv
module stq_bypass #(
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [DEPTH-1:0] ent_vld;
  logic [PW-1:0]    head_ptr;
  logic             push_fire;
  logic             drain_fire;
  logic             rd_issue;
  logic             hit;
  logic [DW-1:0]    fwd_data;

  assign push_ready = !full;
  assign push_fire  = push_valid && !full;
  assign rd_hit     = rd_valid && hit;
  assign rd_data    = rd_hit ? fwd_data : '0;

  stq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_fire), .push_addr(push_addr), .push_data(push_data),
    .pop_en(drain_fire),
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_vld(ent_vld),
    .head_ptr(head_ptr), .full(full), .empty(empty)
  );

  stq_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .rd_addr(rd_addr), .ent_addr(ent_addr), .ent_data(ent_data),
    .ent_vld(ent_vld), .head_ptr(head_ptr),
    .hit(hit), .fwd_data(fwd_data)
  );

  stq_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .hit(hit), .empty(empty),
    .head_addr(ent_addr[head_ptr]), .head_data(ent_data[head_ptr]),
    .mem_gnt(mem_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_ready(rd_ready),
    .rd_issue(rd_issue), .drain_fire(drain_fire)
  );

  AST_EMPTY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !drain_fire) |=> !empty); // R2
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ready); // R3

endmodule

// File: tb/stq_bypass_tb.sv
module stq_bypass_tb;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;
  localparam int AW     = 4;
  localparam int DW     = 8;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, rd_valid = 0, mem_gnt = 0;
  logic [AW-1:0] push_addr = '0, rd_addr = '0;
  logic [DW-1:0] push_data = '0;
  logic push_ready, rd_ready, rd_hit, mem_req, mem_we, full, empty;
  logic [DW-1:0] rd_data, mem_wdata;
  logic [AW-1:0] mem_addr;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];

  always #(CLK_NS/2) clk = ~clk;

  stq_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
    .push_ready(push_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .full(full), .empty(empty)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, check, then update reference at rising edge
  task automatic step(bit pv, int pa, int pd, bit rv, int ra, bit g);
    bit e_full, e_empty, e_hit, e_rdgo, e_drain;
    int e_data;
    @(negedge clk);
    push_valid = pv; push_addr = AW'(pa); push_data = DW'(pd);
    rd_valid = rv; rd_addr = AW'(ra); mem_gnt = g;
    #1;
    e_full  = (qa.size() == DEPTH);
    e_empty = (qa.size() == 0);
    e_hit = 0; e_data = 0;
    for (int i = 0; i < qa.size(); i++)
      if (qa[i] == AW'(ra)) begin e_hit = 1; e_data = qd[i]; end
    e_rdgo  = rv && !e_hit;
    e_drain = !e_rdgo && !e_empty && g;
    chk("R2 full", full, e_full);
    chk("R2 empty", empty, e_empty);
    chk("R3 push_ready", push_ready, !e_full);
    chk("R8 mem_req", mem_req, e_rdgo || !e_empty);
    if (e_rdgo) begin
      chk("R5 mem_we", mem_we, 0);
      chk("R5 mem_addr", mem_addr, ra);
      chk("R5 rd_ready", rd_ready, g);
      chk("R5 rd_hit", rd_hit, 0);
    end else if (!e_empty) begin
      chk("R4 mem_we", mem_we, 1);
      chk("R4 mem_addr", mem_addr, qa[0]);
      chk("R4 mem_wdata", mem_wdata, qd[0]);
    end
    if (rv && e_hit) begin
      chk("R6 rd_hit", rd_hit, 1);
      chk("R6 rd_ready", rd_ready, 1);
      chk("R6 rd_data youngest", rd_data, e_data);
    end
    @(posedge clk);
    if (e_drain) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (pv && !e_full) begin qa.push_back(AW'(pa)); qd.push_back(DW'(pd)); end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 3);
    #1;
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 push_ready", push_ready, 1);
    chk("R1 mem_req", mem_req, 0);
    rst_n = 1;
    // R8: same-cycle push is not yet visible to the read check
    step(1, 7, 8'h11, 1, 7, 0);
    // R2/R3: fill with a repeated address, then a refused fifth push
    step(1, 3, 8'h21, 0, 0, 0);
    step(1, 7, 8'h22, 0, 0, 0);
    step(1, 3, 8'h23, 0, 0, 0);
    step(1, 9, 8'hEE, 0, 0, 0);
    // R3: full with drain in the same cycle still refuses
    step(1, 9, 8'hEF, 0, 0, 1);
    step(1, 9, 8'h24, 0, 0, 0);
    // R6: sweep every read address with no grant
    for (int a = 0; a < (1 << AW); a++) step(0, 0, 0, 1, a, 0);
    // R7: conflict-free read against pending writes with grant
    step(0, 0, 0, 1, 12, 1);
    step(0, 0, 0, 1, 13, 1);
    // R6 with drain in parallel
    step(0, 0, 0, 1, 3, 1);
    // R9: push and drain together, then drain out (R4)
    step(1, 5, 8'h31, 0, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1);
    // mixed random traffic over all addresses and grant patterns
    for (int i = 0; i < 4000; i++)
      step(1'($urandom % 2), int'($urandom % 16), int'($urandom % 256),
           1'(($urandom % 3) == 0), int'($urandom % 16), 1'(($urandom % 3) != 0));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule